// File: doc/BRIEF.md
# SDRAM Low-Power Entry Sequencer

This block sits between an SDRAM access scheduler and the memory's CKE, clock-enable and command pins. While the bus is idle it counts cycles, and after a selectable idle period it places the memory in one of three low-power states: self-refresh, power-down or deep power-down. When the scheduler raises a request, the block runs the wake-up sequence for the state it is leaving. It then waits a programmable exit delay and grants the request. Once the scheduler reports the end of that transfer, the idle countdown starts again.

Self-refresh always stops the memory clock. Power-down stops it only when the clock-freeze input is set. Deep power-down is one-way. The block ignores requests while in that state. When the mode input moves away from deep power-down, the block raises a reinitialisation flag and grants nothing more until reset.

Top module: `lp_entry_seq`

## Requirements
- R1: While reset is held: cke_o=1, mclk_en_o=1, cmd_o=0, grant_o=0, busy_o=0, reinit_o=0.
- R2: With lp_mode_i=0 (disabled), the block issues no entry command (cmd_o stays 0) and cke_o stays 1, however long the bus is idle.
- R3: idle_sel_i gives the idle limit L: 0 gives 0, 1 gives 64, 2 and 3 give 128 cycles. The entry command appears on cmd_o exactly L+1 clock edges after the edge that samples xfer_done_i, provided no request arrives. It lasts one cycle.
- R4: Self-refresh (lp_mode_i=1) entry drives cmd_o=1 and cke_o=0. mclk_en_o=0 whatever clk_freeze_i is.
- R5: Power-down (lp_mode_i=2) entry drives cmd_o=2 and cke_o=0. mclk_en_o equals the inverse of clk_freeze_i.
- R6: Leaving self-refresh on a request: on the edge after the request is sampled, mclk_en_o=1 and cke_o is still 0. One edge later cke_o=1. grant_o rises exactly exit_dly_i+1 edges after cke_o rises.
- R7: Leaving power-down on a request: on the edge that samples the request, cke_o=1 and mclk_en_o=1. grant_o rises exactly exit_dly_i+1 edges later.
- R8: A request during the idle countdown is granted on the next edge. The countdown restarts from zero when that transfer ends.
- R9: While busy_o=1 (from the grant edge until xfer_done_i is sampled), cke_o stays 1 and cmd_o stays 0.
- R10: Deep power-down (lp_mode_i=3) entry drives cmd_o=3, cke_o=0 and mclk_en_o=0. Requests are never granted while lp_mode_i stays 3.
- R11: When lp_mode_i leaves 3 during deep power-down, reinit_o=1, cke_o=1 and mclk_en_o=1 on the next edge. After that no grant occurs until reset, even if lp_mode_i returns to 3.
- R12: A change of lp_mode_i during self-refresh or power-down runs the exit sequence without a grant. The block then returns to idle and re-enters under the new mode. For a power-down exit to self-refresh with idle limit 0, cmd_o=1 appears exit_dly_i+2 edges after cke_o rises.
- R13: grant_o is a one-cycle pulse. busy_o falls on the edge that samples xfer_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode_i | input | 2 | 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| idle_sel_i | input | 2 | Idle limit select: 0, 64, 128, 128 cycles |
| clk_freeze_i | input | 1 | Allow clock stop in power-down |
| exit_dly_i | input | DLY_W | Exit-to-grant delay in cycles |
| req_i | input | 1 | Access request, held until granted |
| xfer_done_i | input | 1 | Pulse at end of the granted transfer |
| grant_o | output | 1 | One-cycle grant pulse |
| busy_o | output | 1 | Transfer in progress |
| cke_o | output | 1 | Memory clock-enable pin |
| mclk_en_o | output | 1 | Memory clock output enable |
| cmd_o | output | 2 | 0 NOP, 1 self-refresh entry, 2 power-down entry, 3 deep power-down entry |
| reinit_o | output | 1 | Memory needs reinitialisation |

## Verification
Some properties are checked on every cycle by the assertions:
- CKE stays high and no entry command appears during a transfer.
- The disabled mode never enters low power.
- Entry commands and grants are single-cycle pulses that coincide with CKE low and follow CKE high, respectively.
- The clock restarts before CKE rises out of self-refresh.
- The reinit flag excludes grants.

Exact cycle counts need the bench's scenarios. These include the idle limit for every timeout code, the exit-to-grant spacing for every delay value in both modes, and the restart of the countdown when a request interrupts it. Only the scenarios can also show the one-way behaviour of deep power-down and the exit and re-entry on a mode change.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_XFER, ST_LP, ST_WAKE_CLK, ST_WAKE, ST_DEEP, ST_REINIT
  } lp_state_e;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0, MODE_SR = 2'd1, MODE_PD = 2'd2, MODE_DEEP = 2'd3
  } lp_mode_e;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0, CMD_SRE = 2'd1, CMD_PDE = 2'd2, CMD_DPD = 2'd3
  } lp_cmd_e;
endpackage

// File: rtl/lp_idle_timer.sv
// Counts idle cycles while run is high; expired once the selected limit is met.
module lp_idle_timer #(
  parameter int SHORT_CYC = 64,
  parameter int LONG_CYC  = 128,
  localparam int CW = $clog2(LONG_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       expired
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd0:    limit = '0;
      2'd1:    limit = CW'(SHORT_CYC);
      default: limit = CW'(LONG_CYC);   // code 3 reserved, behaves as long
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt < limit) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LONG_CYC));
endmodule

// File: rtl/lp_exit_timer.sv
// Counts cycles spent waking; done once the programmed delay is reached.
module lp_exit_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DLY_W-1:0] dly,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt < dly) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt >= dly);

  p_exit_step_r6: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(done) && $past(dly) == dly) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/lp_pin_drv.sv
// Registers the memory-side pins from the sequencer's next state.
module lp_pin_drv
  import lp_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lp_state_e state_q,
  input  lp_state_e state_d,
  input  lp_mode_e  kind_d,
  input  logic      freeze,
  output logic      cke,
  output logic      mclk_en,
  output lp_cmd_e   cmd,
  output logic      busy,
  output logic      reinit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cke     <= 1'b1;
      mclk_en <= 1'b1;
      cmd     <= CMD_NOP;
      busy    <= 1'b0;
      reinit  <= 1'b0;
    end else begin
      cke <= !(state_d == ST_LP || state_d == ST_WAKE_CLK || state_d == ST_DEEP);
      case (state_d)
        ST_LP:   mclk_en <= (kind_d == MODE_PD) && !freeze;
        ST_DEEP: mclk_en <= 1'b0;
        default: mclk_en <= 1'b1;
      endcase
      cmd <= CMD_NOP;
      if (state_d != state_q) begin
        if (state_d == ST_LP)        cmd <= (kind_d == MODE_SR) ? CMD_SRE : CMD_PDE;
        else if (state_d == ST_DEEP) cmd <= CMD_DPD;
      end
      busy   <= (state_d == ST_XFER);
      reinit <= (state_d == ST_REINIT);
    end
  end

  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmd != CMD_NOP |=> cmd == CMD_NOP);
  p_entry_cke_low_r4: assert property (@(posedge clk) disable iff (rst)
    cmd != CMD_NOP |-> !cke);
endmodule

// File: rtl/lp_entry_seq.sv
module lp_entry_seq
  import lp_seq_pkg::*;
#(
  parameter int SHORT_IDLE = 64,
  parameter int LONG_IDLE  = 128,
  parameter int DLY_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       lp_mode_i,
  input  logic [1:0]       idle_sel_i,
  input  logic             clk_freeze_i,
  input  logic [DLY_W-1:0] exit_dly_i,
  input  logic             req_i,
  input  logic             xfer_done_i,
  output logic             grant_o,
  output logic             busy_o,
  output logic             cke_o,
  output logic             mclk_en_o,
  output logic [1:0]       cmd_o,
  output logic             reinit_o
);
  lp_state_e state_q, state_d;
  lp_mode_e  kind_q, kind_d, mode;
  lp_cmd_e   cmd_q;
  logic      grant_d, idle_exp, exit_done;

  assign mode = lp_mode_e'(lp_mode_i);

  lp_idle_timer #(.SHORT_CYC(SHORT_IDLE), .LONG_CYC(LONG_IDLE)) u_idle (
    .clk(clk), .rst(rst), .run(state_q == ST_IDLE), .sel(idle_sel_i), .expired(idle_exp));

  lp_exit_timer #(.DLY_W(DLY_W)) u_exit (
    .clk(clk), .rst(rst), .run(state_q == ST_WAKE), .dly(exit_dly_i), .done(exit_done));

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    grant_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_XFER;
          grant_d = 1'b1;
        end else if (idle_exp && mode != MODE_OFF) begin
          kind_d  = mode;
          state_d = (mode == MODE_DEEP) ? ST_DEEP : ST_LP;
        end
      end
      ST_XFER:     if (xfer_done_i) state_d = ST_IDLE;
      ST_LP:       if (req_i || mode != kind_q)
                     state_d = (kind_q == MODE_SR) ? ST_WAKE_CLK : ST_WAKE;
      ST_WAKE_CLK: state_d = ST_WAKE;
      ST_WAKE: begin
        if (exit_done) begin
          if (req_i) begin
            state_d = ST_XFER;
            grant_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_DEEP:     if (mode != MODE_DEEP) state_d = ST_REINIT;
      ST_REINIT:   state_d = ST_REINIT;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= MODE_OFF;
      grant_o <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      grant_o <= grant_d;
    end
  end

  lp_pin_drv u_pins (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d), .kind_d(kind_d),
    .freeze(clk_freeze_i), .cke(cke_o), .mclk_en(mclk_en_o), .cmd(cmd_q),
    .busy(busy_o), .reinit(reinit_o));

  assign cmd_o = cmd_q;

  p_off_no_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && mode == MODE_OFF) |=> (cmd_o == 2'd0 && cke_o));
  p_busy_cke_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cke_o && cmd_o == 2'd0));
  p_grant_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o);
  p_grant_after_cke_r7: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> $past(cke_o));
  p_clk_before_cke_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke_o) && kind_q == MODE_SR) |-> $past(mclk_en_o));
  p_reinit_no_grant_r11: assert property (@(posedge clk) disable iff (rst)
    reinit_o |-> (!grant_o && !busy_o));
endmodule

// File: tb/lp_entry_seq_tb.sv
`timescale 1ns/1ps
module lp_entry_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] lp_mode = 2'd0, idle_sel = 2'd0;
  logic freeze = 1'b0;
  logic [3:0] dly = 4'd0;
  logic req = 1'b0, xdone = 1'b0;
  logic grant, busy, cke, mclk_en, reinit;
  logic [1:0] cmd;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lp_entry_seq u_dut (
    .clk(clk), .rst(rst), .lp_mode_i(lp_mode), .idle_sel_i(idle_sel),
    .clk_freeze_i(freeze), .exit_dly_i(dly), .req_i(req), .xfer_done_i(xdone),
    .grant_o(grant), .busy_o(busy), .cke_o(cke), .mclk_en_o(mclk_en),
    .cmd_o(cmd), .reinit_o(reinit));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Grant from idle, one busy cycle, then end the transfer (R8, R9, R13).
  task automatic xfer_from_idle();
    req = 1'b1;
    tick();
    chk(grant == 1'b1, "R8 grant next edge", grant, 1);
    req = 1'b0;
    tick();
    chk(grant == 1'b0, "R13 grant pulse", grant, 0);
    chk(busy && cke && cmd == 2'd0, "R9 busy cke", {busy, cke, cmd}, 4'b1100);
    xdone = 1'b1;
    tick();
    xdone = 1'b0;
    chk(busy == 1'b0, "R13 busy falls", busy, 0);
  endtask

  task automatic count_entry(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (cmd == 2'd0 && n < 400);
  endtask

  // Wake from SR (kind 1) or PD (kind 2) and finish the granted transfer.
  task automatic wake(input int kind, input int d);
    int n;
    req = 1'b1;
    tick();
    if (kind == 1) begin
      chk(cke == 1'b0 && mclk_en == 1'b1, "R6 clock first", {cke, mclk_en}, 2'b01);
      tick();
      chk(cke == 1'b1, "R6 cke rises", cke, 1);
    end else begin
      chk(cke == 1'b1 && mclk_en == 1'b1, "R7 cke and clock", {cke, mclk_en}, 2'b11);
    end
    n = 0;
    while (!grant && n < 40) begin
      tick();
      n++;
    end
    chk(n == d + 1, (kind == 1) ? "R6 exit delay" : "R7 exit delay", n, d + 1);
    chk(busy && cke, "R9 busy after wake", {busy, cke}, 2'b11);
    req = 1'b0;
    xdone = 1'b1;
    tick();
    xdone = 1'b0;
    chk(grant == 1'b0 && busy == 1'b0, "R13 end of wake xfer", {grant, busy}, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    @(negedge clk);
    tick();
    tick();
    chk(cke && mclk_en && cmd == 2'd0 && !grant && !busy && !reinit, "R1 reset state",
        {cke, mclk_en, cmd, grant, busy, reinit}, 7'b1100000);
    rst = 1'b0;

    // R2: disabled mode never enters low power
    xfer_from_idle();
    ok = 1;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (!cke || cmd != 2'd0) ok = 0;
    end
    chk(ok, "R2 no entry when off", ok, 1);

    // R3 + R5: sweep of every idle code in power-down
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = (s == 0) ? 0 : (s == 1) ? 64 : 128;
      lp_mode = 2'd2; idle_sel = 2'(s); freeze = 1'b0; dly = 4'(s * 4 + 1);
      xfer_from_idle();
      count_entry(n);
      chk(n == lim + 1, "R3 idle limit", n, lim + 1);
      chk(cmd == 2'd2 && !cke && mclk_en, "R5 pd entry", {cmd, cke, mclk_en}, 4'b1001);
      tick();
      chk(cmd == 2'd0, "R3 entry pulse", cmd, 0);
      wake(2, s * 4 + 1);
    end

    // R4..R7: both modes, both freeze values, every exit delay
    for (int m = 1; m < 3; m++) begin
      for (int f = 0; f < 2; f++) begin
        for (int d = 0; d < 16; d++) begin
          int ck;
          lp_mode = 2'(m); freeze = f[0]; dly = 4'(d); idle_sel = 2'd0;
          xfer_from_idle();
          count_entry(n);
          chk(n == 1, "R3 immediate entry", n, 1);
          ck = (m == 1) ? 0 : (f == 0 ? 1 : 0);
          chk(cmd == 2'(m) && !cke && mclk_en == ck[0],
              (m == 1) ? "R4 sr entry" : "R5 pd entry", {cmd, cke, mclk_en}, {m[1:0], 1'b0, ck[0]});
          wake(m, d);
        end
      end
    end

    // R8: request during the countdown restarts it
    lp_mode = 2'd2; idle_sel = 2'd1; dly = 4'd0; freeze = 1'b0;
    xfer_from_idle();
    repeat (30) tick();
    chk(cmd == 2'd0 && cke, "R8 still counting", {cmd, cke}, 1);
    xfer_from_idle();
    count_entry(n);
    chk(n == 65, "R8 countdown restart", n, 65);
    wake(2, 0);

    // R12: mode change while in power-down
    lp_mode = 2'd2; idle_sel = 2'd0; dly = 4'd3;
    xfer_from_idle();
    count_entry(n);
    chk(cmd == 2'd2, "R12 pd entered", cmd, 2);
    lp_mode = 2'd1;
    tick();
    chk(cke == 1'b1 && grant == 1'b0, "R12 exit on mode change", {cke, grant}, 2'b10);
    n = 0; ok = 1;
    do begin
      tick();
      n++;
      if (grant) ok = 0;
    end while (cmd == 2'd0 && n < 40);
    chk(n == 5, "R12 re-entry timing", n, 5);
    chk(ok && cmd == 2'd1, "R12 no grant, sr entry", {ok, cmd}, 3'b101);
    wake(1, 3);

    // R10, R11: deep power-down is one-way
    lp_mode = 2'd3; idle_sel = 2'd0;
    xfer_from_idle();
    count_entry(n);
    chk(n == 1, "R10 deep entry timing", n, 1);
    chk(cmd == 2'd3 && !cke && !mclk_en, "R10 deep entry", {cmd, cke, mclk_en}, 4'b1100);
    req = 1'b1;
    ok = 1;
    repeat (20) begin
      tick();
      if (grant || cke || busy) ok = 0;
    end
    chk(ok, "R10 request ignored", ok, 1);
    lp_mode = 2'd0;
    tick();
    chk(reinit && cke && mclk_en, "R11 reinit flag", {reinit, cke, mclk_en}, 3'b111);
    ok = 1;
    repeat (10) begin
      tick();
      if (grant || busy || !reinit) ok = 0;
    end
    lp_mode = 2'd3;
    repeat (10) begin
      tick();
      if (grant || busy || !reinit || !cke || cmd != 2'd0) ok = 0;
    end
    chk(ok, "R11 no grant after reinit", ok, 1);
    req = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule